// File: doc/BRIEF.md
# Multi-Mode Mantissa Rounding Unit

This block is the rounding stage used when a wide internal significand is packed into a result. The incoming mantissa has two extra bits below the result's least significant bit. The upper one is the guard bit and the lower one is the round bit. A separate sticky flag records whether any nonzero bits were shifted out earlier. The block removes the two extra bits. It then adds one at the new least significant bit if the selected rounding mode calls for it. It also reports whether the value was inexact and whether it was rounded up.

The path is purely combinational, so the results belong to the same cycle as the inputs. An increment can carry all the way up, for example when a significand of 1.111…1 becomes 2.0. The caller handles that case: it uses the rounded-up indicator to detect the carry into the next binade, then renormalises and adjusts the exponent itself. The sticky output is always zero, because the rounded value absorbs all the discarded information.

Top module: `mant_rounder`

## Requirements
- R1: When no increment is applied, `mant_o` equals `mant_i` shifted right by two bit positions. Bit 1 of `mant_i` is the guard bit and bit 0 is the round bit.
- R2: When guard, round and `sticky_i` are all zero, `inexact_o` and `rounded_up_o` are both 0, in every mode.
- R3: `inexact_o` is 1 exactly when at least one of guard, round or `sticky_i` is 1, in every mode.
- R4: In mode 2'b00 (nearest, ties to even), an increment is applied only when guard is 1 and at least one of these is 1: round, `sticky_i`, or bit 0 of the shifted mantissa (bit 2 of `mant_i`).
- R5: In mode 2'b01 (toward zero), no increment is ever applied.
- R6: In mode 2'b10 (toward minus infinity), an increment is applied exactly when the value is inexact and `sign_i` is 1.
- R7: In mode 2'b11 (toward plus infinity), an increment is applied exactly when the value is inexact and `sign_i` is 0.
- R8: An increment adds one at bit 0 of the shifted mantissa, and the carry runs through all `RES_W` bits. A shifted value of all ones wraps to zero. `rounded_up_o` is 1 exactly when an increment is applied.
- R9: `sticky_o` is always 0.
- R10: The outputs reflect the inputs of the current cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_i | input | RES_W+2 | Mantissa to round; bits 1 and 0 are the guard and round bits |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| sticky_i | input | 1 | Set if any nonzero bits were shifted out below the round bit |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| mant_o | output | RES_W | Rounded mantissa with the guard and round bits removed |
| sticky_o | output | 1 | Sticky flag after rounding; always 0 |
| inexact_o | output | 1 | Rounding discarded nonzero information |
| rounded_up_o | output | 1 | An increment was applied |

## Verification
The bench builds the block with its defaults: a 64-bit result and an incrementer made of 16-bit carry segments. With these values, carries that stop inside one segment, carries that cross one or more segment boundaries, and the full wrap from all ones to zero can all be driven directly. The tie cases for round-to-nearest are driven with both an even and an odd shifted value. Each directed mode is tried with both signs. A seeded sweep then compares all four modes against a model written from the requirements.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    // Rounding mode field. The values are fixed by the R4-R7 requirements.
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TO_ZERO = 2'b01,
        RM_TO_NEG  = 2'b10,
        RM_TO_POS  = 2'b11
    } rmode_e;

    // Bits that sit below the result LSB.
    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
    } tail_t;

endpackage

// File: rtl/rnd_decide.sv
// Decides whether to round up, given the discarded tail, the sign and the mode.
module rnd_decide
    import rnd_pkg::*;
(
    input  tail_t  tail_i,
    input  logic   lsb_i,
    input  logic   sign_i,
    input  rmode_e mode_i,
    output logic   inexact_o,
    output logic   bump_o
);

    logic lost;

    always_comb begin
        lost      = tail_i.guard | tail_i.rnd | tail_i.sticky;
        inexact_o = lost;
        bump_o    = 1'b0;
        unique case (mode_i)
            RM_NEAREST: bump_o = tail_i.guard & (tail_i.rnd | tail_i.sticky | lsb_i);
            RM_TO_ZERO: bump_o = 1'b0;
            RM_TO_NEG:  bump_o = lost & sign_i;
            RM_TO_POS:  bump_o = lost & ~sign_i;
            default:    bump_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd_incr.sv
// Adds cin_i at bit 0. The adder is split into fixed-width segments, and a
// carry enters a segment only when every lower segment is all ones.
module rnd_incr #(
    parameter int W     = 64,
    parameter int SEG_W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);

    localparam int NSEG = (W + SEG_W - 1) / SEG_W;
    localparam int PADW = NSEG * SEG_W;

    logic [PADW-1:0] padded;
    logic [PADW-1:0] summed;
    logic [NSEG:0]   carry;

    assign padded   = {{(PADW - W){1'b0}}, val_i};
    assign carry[0] = cin_i;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [SEG_W-1:0] part;
        assign part                         = padded[s*SEG_W +: SEG_W];
        assign summed[s*SEG_W +: SEG_W]     = part + {{(SEG_W - 1){1'b0}}, carry[s]};
        assign carry[s+1]                   = carry[s] & (&part);
    end

    assign sum_o = summed[W-1:0];

endmodule

// File: rtl/mant_rounder.sv
// Combinational rounding stage: removes the guard and round bits and
// rounds according to mode_i.
module mant_rounder
    import rnd_pkg::*;
#(
    parameter int RES_W   = 64,
    parameter int CHUNK_W = 16
) (
    input  logic [RES_W+1:0] mant_i,
    input  logic             sign_i,
    input  logic             sticky_i,
    input  logic [1:0]       mode_i,
    output logic [RES_W-1:0] mant_o,
    output logic             sticky_o,
    output logic             inexact_o,
    output logic             rounded_up_o
);

    tail_t            tail;
    rmode_e           mode;
    logic [RES_W-1:0] shifted;
    logic             bump;

    assign tail    = '{guard: mant_i[1], rnd: mant_i[0], sticky: sticky_i};
    assign mode    = rmode_e'(mode_i);
    assign shifted = mant_i[RES_W+1:2];

    rnd_decide u_decide (
        .tail_i    (tail),
        .lsb_i     (shifted[0]),
        .sign_i    (sign_i),
        .mode_i    (mode),
        .inexact_o (inexact_o),
        .bump_o    (bump)
    );

    rnd_incr #(
        .W     (RES_W),
        .SEG_W (CHUNK_W)
    ) u_incr (
        .val_i (shifted),
        .cin_i (bump),
        .sum_o (mant_o)
    );

    assign rounded_up_o = bump;
    assign sticky_o     = 1'b0;

endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
    parameter int RES_W = 64
) (
    input logic [RES_W+1:0] mant_i,
    input logic             sign_i,
    input logic             sticky_i,
    input logic [1:0]       mode_i,
    input logic [RES_W-1:0] mant_o,
    input logic             sticky_o,
    input logic             inexact_o,
    input logic             rounded_up_o
);

    logic [RES_W-1:0] trunc;
    logic             any_tail;

    assign trunc    = mant_i[RES_W+1:2];
    assign any_tail = mant_i[1] | mant_i[0] | sticky_i;

    always_comb begin
        if (!rounded_up_o)
            AST_PLAIN_SHIFT: assert (mant_o == trunc) else $error("plain shift broken"); // R1
        if (!any_tail)
            AST_EXACT_QUIET: assert (!inexact_o && !rounded_up_o) else $error("exact flagged"); // R2
        AST_INEXACT_MATCH: assert (inexact_o == any_tail) else $error("inexact mismatch"); // R3
        if (mode_i == 2'b00 && !mant_i[1])
            AST_NEAR_NO_GUARD: assert (!rounded_up_o) else $error("nearest rounded without guard"); // R4
        if (mode_i == 2'b01)
            AST_ZERO_NEVER_UP: assert (!rounded_up_o) else $error("toward zero incremented"); // R5
        if (mode_i == 2'b10)
            AST_NEG_DIR: assert (rounded_up_o == (any_tail && sign_i)) else $error("minus-inf mismatch"); // R6
        if (mode_i == 2'b11)
            AST_POS_DIR: assert (rounded_up_o == (any_tail && !sign_i)) else $error("plus-inf mismatch"); // R7
        if (rounded_up_o)
            AST_BUMP_ONE: assert (mant_o == trunc + 1'b1) else $error("increment wrong"); // R8
        AST_STICKY_CLEAR: assert (!sticky_o) else $error("sticky not cleared"); // R9
    end

endmodule

bind mant_rounder mant_rounder_chk #(.RES_W(RES_W)) u_chk (
    .mant_i       (mant_i),
    .sign_i       (sign_i),
    .sticky_i     (sticky_i),
    .mode_i       (mode_i),
    .mant_o       (mant_o),
    .sticky_o     (sticky_o),
    .inexact_o    (inexact_o),
    .rounded_up_o (rounded_up_o)
);

// File: tb/sim_mant_rounder.sv
`timescale 1ns/1ps
module sim_mant_rounder;

    localparam int RES_W = 64;
    localparam int WATCHDOG = 50000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [RES_W+1:0] mant_i = '0;
    logic             sign_i = 1'b0;
    logic             sticky_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [RES_W-1:0] mant_o;
    logic             sticky_o, inexact_o, rounded_up_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mant_rounder #(.RES_W(RES_W), .CHUNK_W(16)) u0 (
        .mant_i(mant_i), .sign_i(sign_i), .sticky_i(sticky_i), .mode_i(mode_i),
        .mant_o(mant_o), .sticky_o(sticky_o), .inexact_o(inexact_o),
        .rounded_up_o(rounded_up_o)
    );

    // Expected results, written directly from the requirements.
    function automatic logic [RES_W+1:0] model(input logic [RES_W+1:0] m, input logic s,
                                               input logic st, input logic [1:0] md);
        logic g, r, inex, up;
        logic [RES_W-1:0] res;
        g = m[1];
        r = m[0];
        inex = g | r | st;
        case (md)
            2'b00:   up = g & (r | st | m[2]);
            2'b01:   up = 1'b0;
            2'b10:   up = inex & s;
            default: up = inex & ~s;
        endcase
        res = m[RES_W+1:2] + {{(RES_W-1){1'b0}}, up};
        return {res, inex, up};
    endfunction

    task automatic apply(input logic [RES_W+1:0] m, input logic s, input logic st,
                         input logic [1:0] md, input string req);
        logic [RES_W+1:0] e;
        @(negedge clk);
        mant_i = m; sign_i = s; sticky_i = st; mode_i = md;
        #1;
        e = model(m, s, st, md);
        n_checks++;
        if (mant_o !== e[RES_W+1:2] || inexact_o !== e[1] || rounded_up_o !== e[0] || sticky_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: got mant=%h inex=%b up=%b sticky=%b expected mant=%h inex=%b up=%b sticky=0",
                     req, mant_o, inexact_o, rounded_up_o, sticky_o, e[RES_W+1:2], e[1], e[0]);
        end
    endtask

    task automatic expect_val(input logic [RES_W-1:0] want, input logic want_up, input string req);
        n_checks++;
        if (mant_o !== want || rounded_up_o !== want_up) begin
            n_fail++;
            $display("FAIL %s: got mant=%h up=%b expected mant=%h up=%b", req, mant_o, rounded_up_o, want, want_up);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk); #1;
        n_checks++;
        if (mant_o !== '0 || inexact_o !== 1'b0 || rounded_up_o !== 1'b0 || sticky_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset: got mant=%h inex=%b up=%b expected 0 0 0", mant_o, inexact_o, rounded_up_o);
        end
    endtask

    task automatic t_exact();
        for (int md = 0; md < 4; md++) begin
            apply({64'h0123_4567_89AB_CDEF, 2'b00}, 1'b1, 1'b0, md[1:0], "R2 exact");
            expect_val(64'h0123_4567_89AB_CDEF, 1'b0, "R1 shift");
        end
    endtask

    task automatic t_nearest();
        apply({64'h10, 2'b01}, 1'b0, 1'b0, 2'b00, "R4 below half");
        expect_val(64'h10, 1'b0, "R4 below half");
        apply({64'h10, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie even");
        expect_val(64'h10, 1'b0, "R4 tie even");
        apply({64'h11, 2'b10}, 1'b0, 1'b0, 2'b00, "R4 tie odd");
        expect_val(64'h12, 1'b1, "R4 tie odd");
        apply({64'h10, 2'b11}, 1'b1, 1'b0, 2'b00, "R4 above half");
        expect_val(64'h11, 1'b1, "R4 above half");
        apply({64'h10, 2'b10}, 1'b0, 1'b1, 2'b00, "R4 sticky breaks tie");
        expect_val(64'h11, 1'b1, "R4 sticky breaks tie");
        apply({64'h10, 2'b00}, 1'b0, 1'b1, 2'b00, "R3 sticky only");
    endtask

    task automatic t_to_zero();
        apply({64'h7, 2'b11}, 1'b0, 1'b1, 2'b01, "R5 pos");
        expect_val(64'h7, 1'b0, "R5 pos");
        apply({64'h7, 2'b11}, 1'b1, 1'b1, 2'b01, "R5 neg");
    endtask

    task automatic t_directed_inf();
        apply({64'h20, 2'b01}, 1'b1, 1'b0, 2'b10, "R6 neg up");
        expect_val(64'h21, 1'b1, "R6 neg up");
        apply({64'h20, 2'b01}, 1'b0, 1'b0, 2'b10, "R6 pos down");
        apply({64'h20, 2'b00}, 1'b1, 1'b0, 2'b10, "R6 exact neg");
        apply({64'h20, 2'b00}, 1'b0, 1'b1, 2'b11, "R7 pos up");
        expect_val(64'h21, 1'b1, "R7 pos up");
        apply({64'h20, 2'b10}, 1'b1, 1'b0, 2'b11, "R7 neg down");
    endtask

    task automatic t_carry();
        apply({64'h0000_0000_0000_FFFF, 2'b11}, 1'b0, 1'b0, 2'b00, "R8 one segment");
        expect_val(64'h0000_0000_0001_0000, 1'b1, "R8 one segment");
        apply({64'h0000_FFFF_FFFF_FFFF, 2'b01}, 1'b0, 1'b0, 2'b11, "R8 three segments");
        expect_val(64'h0001_0000_0000_0000, 1'b1, "R8 three segments");
        apply({64'h7FFF_FFFF_FFFF_FFFF, 2'b10}, 1'b0, 1'b0, 2'b00, "R8 to 2.0");
        expect_val(64'h8000_0000_0000_0000, 1'b1, "R8 to 2.0");
        apply({64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b1, 1'b0, 2'b10, "R8 wrap");
        expect_val(64'h0, 1'b1, "R8 wrap");
    endtask

    task automatic t_same_cycle();
        // R10: a fresh input is visible 1 ns later, with no clock edge in between.
        @(negedge clk);
        mant_i = {64'h55, 2'b11}; sign_i = 1'b0; sticky_i = 1'b0; mode_i = 2'b11;
        #1;
        expect_val(64'h56, 1'b1, "R10 same cycle");
        n_checks++;
        if (sticky_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 sticky: got %b expected 0", sticky_o);
        end
    endtask

    task automatic t_sweep();
        logic [RES_W+1:0] m;
        for (int i = 0; i < 200; i++) begin
            m = {$urandom(), $urandom(), $urandom()};
            apply(m, i[0], i[3], i[2:1], "R3 sweep");
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_exact();
        t_nearest();
        t_to_zero();
        t_directed_inf();
        t_carry();
        t_same_cycle();
        t_sweep();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule